// File: doc/BRIEF.md
# USB Host Channel Controller

This block manages one host-side USB channel. Software loads a transfer descriptor: the byte total, the number of packets with short packets included, and the starting data PID. It also loads the endpoint characteristics and then starts the channel. While the channel runs, it places transaction requests into a four-entry request queue. Other channels share this queue. A bus scheduler takes entries from the head of the queue. For each packet that completes on the bus, the block lowers the packet and byte counters and flips the PID between DATA0 and DATA1.

The channel stops in one of two ways. It stops by itself when the packet count reaches zero. It also stops when software asks it to. A halt request drops this channel's queued requests and leaves the entries of other channels in order. A transaction already on the bus runs to the end, and only then does the channel report that it has halted. The halt is accepted only when the queue has at least one free slot. A separate flush-only command drops the queued requests without halting, which clears a full queue. Each status flag reaches the interrupt line only when three masks all allow it: the mask for that cause, the mask for the channel, and the global channel mask.

Top module: `usbh_chan_ctrl`

## Requirements
- R1: After reset the channel is IDLE, both status flags are clear, `irq` is low and the queue is empty (`q_level` = 0).
- R2: Register 1 holds bytes in [18:0], packets in [28:19] and the PID in bit 29 (0 = DATA0, 1 = DATA1). Register 1 and the characteristic bits [5:2] of register 0 can be written only in IDLE, and writes in any other state leave them unchanged.
- R3: Writing register 0 with bit0 (enable) = 1 and bit1 (disable) = 0 in IDLE, with a nonzero packet count, moves the channel to ACTIVE. In ACTIVE it posts one request per cycle, tagged `CHAN_ID`, until queued requests plus the in-flight transaction equal the remaining packets. In IDLE it posts nothing.
- R4: The queue holds at most 4 entries and keeps them in arrival order. The channel does not post while the queue is full. An external push has priority over the channel's own post in the same cycle.
- R5: When `xact_done` and `xact_ok` arrive for the channel's in-flight transaction, the packet count drops by one, `xact_len` is subtracted from the byte count (floored at zero) and the PID toggles. A failed completion leaves all three values unchanged.
- R6: When the packet count reaches zero, the channel sets the done flag (register 2 bit1) and the halted flag (register 2 bit0) and enters HALTED. Register 2 bits [5:4] read the state: IDLE=0, ACTIVE=1, HALTING=2, HALTED=3.
- R7: Writing disable=1 with enable=1 in ACTIVE while the queue is not full removes every entry of this channel, keeps the other entries in order, and enters HALTING. HALTING moves to HALTED once nothing is in flight.
- R8: In HALTING with a transaction in flight, the halted flag stays clear until that transaction completes, and a successful result is still counted.
- R9: A disable=1, enable=1 write while the queue is full is ignored, and the channel stays ACTIVE.
- R10: Writing disable=1 with enable=0 in ACTIVE removes this channel's queued entries and leaves the state unchanged.
- R11: Register 2 flags are cleared by writing 1 to them. Clearing the halted flag moves HALTED to IDLE.
- R12: `irq` is high when bit9 (global) and bit8 (channel) of register 3 are set and at least one flag is set whose cause mask is set (bit0 = halted, bit1 = done).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| ext_push | input | 1 | Another channel pushes a request |
| ext_tag | input | TAG_W | Tag of the external request |
| q_pop | input | 1 | Scheduler takes the head entry |
| q_head_valid | output | 1 | Queue is not empty |
| q_head_tag | output | TAG_W | Tag of the head entry |
| q_level | output | 3 | Entries in the queue |
| xact_done | input | 1 | Bus transaction finished |
| xact_ok | input | 1 | Finished transaction succeeded |
| xact_len | input | LEN_W | Bytes moved by the transaction |
| irq | output | 1 | Masked channel interrupt |

## Verification
The hardest state to reach is a halt request that arrives while the queue is full and a transaction is on the bus. The bench first fills the queue with a five-packet transfer. It then pops one entry so that a transaction is in flight, and the channel refills the freed slot. A halt attempt in that state must be refused. A flush-only write then empties the queue, and a halt written in the very next cycle is accepted. Before the completion pulse is applied, the bench checks that the channel stays in HALTING while the bus transaction is outstanding.

// File: rtl/usbh_chan_pkg.sv
package usbh_chan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_HALTING = 2'd2,
        ST_HALTED  = 2'd3
    } ch_state_e;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_SIZE = 2'd1;
    localparam logic [1:0] REG_FLAG = 2'd2;
    localparam logic [1:0] REG_MASK = 2'd3;

    localparam int NCAUSE    = 2;
    localparam int CAUSE_HLT = 0;
    localparam int CAUSE_DON = 1;

    typedef struct packed {
        logic       low_spd;
        logic [1:0] ep_type;
        logic       dir_in;
    } ch_char_t;

    typedef struct packed {
        logic start;
        logic halt;
        logic flush;
    } ch_cmd_t;

    function automatic ch_cmd_t decode_cmd(input logic wr, input logic en,
                                           input logic dis, input ch_state_e st,
                                           input logic pkt_nz, input logic q_full);
        ch_cmd_t c;
        c.start = wr && en && !dis && st == ST_IDLE && pkt_nz;
        c.halt  = wr && en && dis && st == ST_ACTIVE && !q_full;
        c.flush = wr && !en && dis && st == ST_ACTIVE;
        return c;
    endfunction

endpackage

// File: rtl/hc_req_queue.sv
module hc_req_queue #(
    parameter int DEPTH   = 4,
    parameter int TAG_W   = 3,
    parameter int OWN_TAG = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [TAG_W-1:0]           push_tag,
    input  logic                       pop,
    input  logic                       flush_own,
    output logic                       head_valid,
    output logic [TAG_W-1:0]           head_tag,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] own_cnt
);
    localparam int LVL_W = $clog2(DEPTH+1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [TAG_W-1:0] slot_q [DEPTH];
    logic [TAG_W-1:0] shifted [DEPTH];
    logic [TAG_W-1:0] packed_d [DEPTH];
    logic [LVL_W-1:0] lvl_q, n_pop, k;

    always_comb begin
        n_pop = lvl_q;
        for (int i = 0; i < DEPTH; i++) shifted[i] = slot_q[i];
        if (pop && lvl_q != '0) begin
            for (int i = 0; i < DEPTH - 1; i++) shifted[i] = slot_q[i+1];
            shifted[DEPTH-1] = '0;
            n_pop = lvl_q - 1'b1;
        end
        for (int i = 0; i < DEPTH; i++) packed_d[i] = '0;
        k = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (LVL_W'(i) < n_pop &&
                !(flush_own && shifted[i] == TAG_W'(OWN_TAG))) begin
                packed_d[IDX_W'(k)] = shifted[i];
                k = k + 1'b1;
            end
        end
        if (push && k < LVL_W'(DEPTH)) begin
            packed_d[IDX_W'(k)] = push_tag;
            k = k + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else begin
            lvl_q <= k;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= packed_d[i];
        end
    end

    always_comb begin
        own_cnt = '0;
        for (int i = 0; i < DEPTH; i++)
            if (LVL_W'(i) < lvl_q && slot_q[i] == TAG_W'(OWN_TAG))
                own_cnt = own_cnt + 1'b1;
    end

    assign level      = lvl_q;
    assign full       = (lvl_q == LVL_W'(DEPTH));
    assign head_valid = (lvl_q != '0);
    assign head_tag   = slot_q[0];
endmodule

// File: rtl/hc_xfer_ctr.sv
module hc_xfer_ctr #(
    parameter int BYTE_W = 19,
    parameter int PKT_W  = 10,
    parameter int LEN_W  = 11,
    parameter int LVL_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_bytes,
    input  logic [PKT_W-1:0]  load_pkts,
    input  logic              load_pid,
    input  logic              own_pop,
    input  logic              xact_done,
    input  logic              xact_ok,
    input  logic [LEN_W-1:0]  xact_len,
    input  logic [LVL_W-1:0]  own_cnt,
    output logic [BYTE_W-1:0] bytes,
    output logic [PKT_W-1:0]  pkts,
    output logic              pid,
    output logic              inflight,
    output logic              want_post,
    output logic              last_done,
    output logic              fin
);
    logic [BYTE_W-1:0] bytes_q;
    logic [PKT_W-1:0]  pkts_q;
    logic              pid_q, infl_q, good;
    logic [BYTE_W-1:0] len_ext;

    assign len_ext   = BYTE_W'(xact_len);
    assign fin       = xact_done && infl_q;
    assign good      = fin && xact_ok;
    assign last_done = good && pkts_q == PKT_W'(1);
    assign want_post = (PKT_W'(own_cnt) + PKT_W'(infl_q)) < pkts_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bytes_q <= '0;
            pkts_q  <= '0;
            pid_q   <= 1'b0;
            infl_q  <= 1'b0;
        end else begin
            if (load) begin
                bytes_q <= load_bytes;
                pkts_q  <= load_pkts;
                pid_q   <= load_pid;
            end else if (good) begin
                bytes_q <= (bytes_q > len_ext) ? bytes_q - len_ext : '0;
                pkts_q  <= pkts_q - 1'b1;
                pid_q   <= ~pid_q;
            end
            if (own_pop)  infl_q <= 1'b1;
            else if (fin) infl_q <= 1'b0;
        end
    end

    assign bytes    = bytes_q;
    assign pkts     = pkts_q;
    assign pid      = pid_q;
    assign inflight = infl_q;
endmodule

// File: rtl/hc_chan_fsm.sv
module hc_chan_fsm
    import usbh_chan_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ch_cmd_t   cmd,
    input  logic      last_done,
    input  logic      inflight,
    input  logic      fin,
    input  logic      clr_halted,
    output ch_state_e state,
    output logic      set_halted
);
    ch_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (cmd.start) st_d = ST_ACTIVE;
            ST_ACTIVE:  if (last_done) st_d = ST_HALTED;
                        else if (cmd.halt) st_d = ST_HALTING;
            ST_HALTING: if (!inflight || fin) st_d = ST_HALTED;
            ST_HALTED:  if (clr_halted) st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    assign state      = st_q;
    assign set_halted = (st_d == ST_HALTED) && (st_q != ST_HALTED);
endmodule

// File: rtl/hc_irq_mask.sv
module hc_irq_mask #(
    parameter int N = 2
) (
    input  logic [N-1:0] flags,
    input  logic [N-1:0] cause_en,
    input  logic         chan_en,
    input  logic         glob_en,
    output logic         irq
);
    logic [N-1:0] hit;
    for (genvar g = 0; g < N; g++) begin : g_cause
        assign hit[g] = flags[g] & cause_en[g];
    end
    assign irq = glob_en & chan_en & (|hit);
endmodule

// File: rtl/usbh_chan_ctrl.sv
module usbh_chan_ctrl
    import usbh_chan_pkg::*;
#(
    parameter int CHAN_ID = 2,
    parameter int TAG_W   = 3,
    parameter int QDEPTH  = 4,
    parameter int BYTE_W  = 19,
    parameter int PKT_W   = 10,
    parameter int LEN_W   = 11
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [1:0]                  wr_addr,
    input  logic [31:0]                 wr_data,
    input  logic [1:0]                  rd_addr,
    output logic [31:0]                 rd_data,
    input  logic                        ext_push,
    input  logic [TAG_W-1:0]            ext_tag,
    input  logic                        q_pop,
    output logic                        q_head_valid,
    output logic [TAG_W-1:0]            q_head_tag,
    output logic [$clog2(QDEPTH+1)-1:0] q_level,
    input  logic                        xact_done,
    input  logic                        xact_ok,
    input  logic [LEN_W-1:0]            xact_len,
    output logic                        irq
);
    localparam int LVL_W   = $clog2(QDEPTH+1);
    localparam int PKT_LSB = BYTE_W;
    localparam int PID_BIT = BYTE_W + PKT_W;

    ch_state_e         state;
    ch_cmd_t           cmd;
    ch_char_t          char_q;
    logic [NCAUSE-1:0] flags_q, cause_msk_q;
    logic              chan_msk_q, glob_msk_q;
    logic              wr_ctrl, wr_size, wr_flag, wr_mask;
    logic              q_full, own_post, q_push, own_pop, flush_now;
    logic [TAG_W-1:0]  push_tag;
    logic [LVL_W-1:0]  own_cnt;
    logic [BYTE_W-1:0] bytes;
    logic [PKT_W-1:0]  pkts;
    logic              pid, inflight, want_post, last_done, fin, set_halted;
    logic              clr_halted;

    assign wr_ctrl = wr_en && wr_addr == REG_CTRL;
    assign wr_size = wr_en && wr_addr == REG_SIZE;
    assign wr_flag = wr_en && wr_addr == REG_FLAG;
    assign wr_mask = wr_en && wr_addr == REG_MASK;

    assign cmd = decode_cmd(wr_ctrl, wr_data[0], wr_data[1], state,
                            pkts != '0, q_full);
    assign flush_now  = cmd.halt || cmd.flush;
    assign clr_halted = wr_flag && wr_data[CAUSE_HLT];

    assign own_post = state == ST_ACTIVE && !flush_now && !ext_push &&
                      want_post && !q_full;
    assign q_push   = ext_push || own_post;
    assign push_tag = ext_push ? ext_tag : TAG_W'(CHAN_ID);
    assign own_pop  = q_pop && q_head_valid && q_head_tag == TAG_W'(CHAN_ID);

    hc_req_queue #(.DEPTH(QDEPTH), .TAG_W(TAG_W), .OWN_TAG(CHAN_ID)) u_queue (
        .clk(clk), .rst(rst), .push(q_push), .push_tag(push_tag), .pop(q_pop),
        .flush_own(flush_now), .head_valid(q_head_valid), .head_tag(q_head_tag),
        .level(q_level), .full(q_full), .own_cnt(own_cnt)
    );

    hc_xfer_ctr #(.BYTE_W(BYTE_W), .PKT_W(PKT_W), .LEN_W(LEN_W), .LVL_W(LVL_W)) u_xfer (
        .clk(clk), .rst(rst), .load(wr_size && state == ST_IDLE),
        .load_bytes(wr_data[BYTE_W-1:0]), .load_pkts(wr_data[PKT_LSB +: PKT_W]),
        .load_pid(wr_data[PID_BIT]), .own_pop(own_pop), .xact_done(xact_done),
        .xact_ok(xact_ok), .xact_len(xact_len), .own_cnt(own_cnt), .bytes(bytes),
        .pkts(pkts), .pid(pid), .inflight(inflight), .want_post(want_post),
        .last_done(last_done), .fin(fin)
    );

    hc_chan_fsm u_fsm (
        .clk(clk), .rst(rst), .cmd(cmd), .last_done(last_done),
        .inflight(inflight), .fin(fin), .clr_halted(clr_halted),
        .state(state), .set_halted(set_halted)
    );

    hc_irq_mask #(.N(NCAUSE)) u_irq (
        .flags(flags_q), .cause_en(cause_msk_q), .chan_en(chan_msk_q),
        .glob_en(glob_msk_q), .irq(irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            char_q      <= '0;
            flags_q     <= '0;
            cause_msk_q <= '0;
            chan_msk_q  <= 1'b0;
            glob_msk_q  <= 1'b0;
        end else begin
            if (wr_ctrl && state == ST_IDLE) char_q <= ch_char_t'(wr_data[5:2]);
            if (wr_mask) begin
                cause_msk_q <= wr_data[NCAUSE-1:0];
                chan_msk_q  <= wr_data[8];
                glob_msk_q  <= wr_data[9];
            end
            for (int i = 0; i < NCAUSE; i++) begin
                if (wr_flag && wr_data[i]) flags_q[i] <= 1'b0;
            end
            if (set_halted) flags_q[CAUSE_HLT] <= 1'b1;
            if (last_done)  flags_q[CAUSE_DON] <= 1'b1;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            REG_CTRL: begin
                rd_data[5:2] = char_q;
                rd_data[0]   = (state == ST_ACTIVE) || (state == ST_HALTING);
            end
            REG_SIZE: begin
                rd_data[BYTE_W-1:0]      = bytes;
                rd_data[PKT_LSB +: PKT_W] = pkts;
                rd_data[PID_BIT]         = pid;
            end
            REG_FLAG: begin
                rd_data[NCAUSE-1:0] = flags_q;
                rd_data[5:4]        = state;
            end
            default: begin
                rd_data[NCAUSE-1:0] = cause_msk_q;
                rd_data[8]          = chan_msk_q;
                rd_data[9]          = glob_msk_q;
            end
        endcase
    end
endmodule

// File: rtl/hc_chan_chk.sv
module hc_chan_chk
    import usbh_chan_pkg::*;
#(
    parameter int QDEPTH = 4,
    parameter int LVL_W  = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [LVL_W-1:0] q_level,
    input logic [LVL_W-1:0] own_cnt,
    input ch_state_e        state,
    input logic [1:0]       flags_q,
    input logic             inflight,
    input logic             fin,
    input logic             flush_now,
    input logic             irq,
    input logic             chan_msk_q,
    input logic             glob_msk_q
);
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        q_level <= LVL_W'(QDEPTH));

    p_idle_clean_r3: assert property (@(posedge clk) disable iff (rst)
        state == ST_IDLE |-> own_cnt == '0 && !inflight);

    p_flush_empties_r7: assert property (@(posedge clk) disable iff (rst)
        flush_now |=> own_cnt == '0);

    p_halt_waits_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALTING && inflight && !fin) |=> state == ST_HALTING && !flags_q[0]);

    p_halted_state_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_q[0]) |-> state == ST_HALTED);

    p_irq_gated_r12: assert property (@(posedge clk) disable iff (rst)
        irq |-> glob_msk_q && chan_msk_q && flags_q != '0);
endmodule

bind usbh_chan_ctrl hc_chan_chk #(.QDEPTH(QDEPTH), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst(rst), .q_level(q_level), .own_cnt(own_cnt), .state(state),
    .flags_q(flags_q), .inflight(inflight), .fin(fin), .flush_now(flush_now),
    .irq(irq), .chan_msk_q(chan_msk_q), .glob_msk_q(glob_msk_q)
);

// File: tb/sim_usbh_chan_ctrl.sv
`timescale 1ns/1ps
module sim_usbh_chan_ctrl;
    localparam int ID = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        ext_push = 1'b0;
    logic [2:0]  ext_tag = '0;
    logic        q_pop = 1'b0;
    logic        q_head_valid;
    logic [2:0]  q_head_tag;
    logic [2:0]  q_level;
    logic        xact_done = 1'b0;
    logic        xact_ok = 1'b0;
    logic [10:0] xact_len = '0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    usbh_chan_ctrl #(.CHAN_ID(ID)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ext_push(ext_push), .ext_tag(ext_tag),
        .q_pop(q_pop), .q_head_valid(q_head_valid), .q_head_tag(q_head_tag),
        .q_level(q_level), .xact_done(xact_done), .xact_ok(xact_ok),
        .xact_len(xact_len), .irq(irq)
    );

    function automatic logic [31:0] size_word(int pkts, int bytes, bit pid);
        return (32'(pid) << 29) | (32'(pkts) << 19) | 32'(bytes);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic pop1();
        q_pop = 1'b1;
        @(negedge clk);
        q_pop = 1'b0;
    endtask

    task automatic done1(bit ok, int len);
        xact_done = 1'b1; xact_ok = ok; xact_len = 11'(len);
        @(negedge clk);
        xact_done = 1'b0; xact_ok = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd2, v);
        check("R1 flags/state", v, 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 level", 32'(q_level), 32'h0);
    endtask

    task automatic t_transfer();
        logic [31:0] v;
        wr(2'd3, 32'h303);
        wr(2'd1, size_word(3, 1000, 0));
        rd(2'd1, v);
        check("R2 size readback", v, size_word(3, 1000, 0));
        wr(2'd0, 32'h5);
        repeat (5) @(negedge clk);
        check("R3 posted up to packets", 32'(q_level), 32'd3);
        check("R3 head tag", 32'(q_head_tag), 32'(ID));
        wr(2'd1, size_word(7, 7, 1));
        wr(2'd0, 32'h3C);
        rd(2'd1, v);
        check("R2 size locked when active", v, size_word(3, 1000, 0));
        rd(2'd0, v);
        check("R2 characteristics locked", v, 32'h5);
        pop1();
        done1(1, 400);
        rd(2'd1, v);
        check("R5 first packet", v, size_word(2, 600, 1));
        check("R3 no extra post", 32'(q_level), 32'd2);
        pop1();
        done1(0, 400);
        rd(2'd1, v);
        check("R5 failed packet no change", v, size_word(2, 600, 1));
        pop1();
        done1(1, 400);
        rd(2'd1, v);
        check("R5 second packet", v, size_word(1, 200, 0));
        pop1();
        done1(1, 250);
        rd(2'd1, v);
        check("R5 byte floor at zero", v, size_word(0, 0, 1));
        rd(2'd2, v);
        check("R6 auto halt and done", v, 32'h33);
        check("R12 irq all masks open", 32'(irq), 32'h1);
        wr(2'd3, 32'h103);
        check("R12 global mask closes irq", 32'(irq), 32'h0);
        wr(2'd3, 32'h203);
        check("R12 channel mask closes irq", 32'(irq), 32'h0);
        wr(2'd3, 32'h302);
        wr(2'd2, 32'h1);
        rd(2'd2, v);
        check("R11 halted cleared to idle", v, 32'h02);
        check("R12 done cause still raises irq", 32'(irq), 32'h1);
        wr(2'd2, 32'h2);
        rd(2'd2, v);
        check("R11 done cleared", v, 32'h0);
        check("R12 irq low", 32'(irq), 32'h0);
    endtask

    task automatic t_halt_shared();
        logic [31:0] v;
        wr(2'd3, 32'h301);
        wr(2'd1, size_word(2, 128, 0));
        ext_push = 1'b1; ext_tag = 3'd5;
        @(negedge clk);
        ext_push = 1'b0;
        check("R4 external entry", 32'(q_level), 32'd1);
        repeat (2) @(negedge clk);
        check("R3 idle posts nothing", 32'(q_level), 32'd1);
        wr(2'd0, 32'h1);
        repeat (4) @(negedge clk);
        check("R3 posted behind external", 32'(q_level), 32'd3);
        check("R4 order kept", 32'(q_head_tag), 32'd5);
        wr(2'd0, 32'h3);
        check("R7 own entries removed", 32'(q_level), 32'd1);
        check("R7 other entry kept", 32'(q_head_tag), 32'd5);
        rd(2'd2, v);
        check("R7 halting", v, 32'h20);
        @(negedge clk);
        rd(2'd2, v);
        check("R7 halted", v, 32'h31);
        check("R12 halted irq", 32'(irq), 32'h1);
        wr(2'd2, 32'h1);
        pop1();
        rd(2'd2, v);
        check("R11 back to idle", v, 32'h0);
        check("R4 queue drained", 32'(q_level), 32'd0);
    endtask

    task automatic t_full_inflight();
        logic [31:0] v;
        wr(2'd1, size_word(5, 320, 0));
        wr(2'd0, 32'h1);
        repeat (6) @(negedge clk);
        check("R4 queue full", 32'(q_level), 32'd4);
        pop1();
        @(negedge clk);
        check("R4 refilled to depth", 32'(q_level), 32'd4);
        wr(2'd0, 32'h3);
        rd(2'd2, v);
        check("R9 halt refused when full", v, 32'h10);
        wr(2'd0, 32'h2);
        check("R10 flush-only empties", 32'(q_level), 32'd0);
        rd(2'd2, v);
        check("R10 state unchanged", v, 32'h10);
        wr(2'd0, 32'h3);
        check("R7 no repost after halt", 32'(q_level), 32'd0);
        repeat (3) @(negedge clk);
        rd(2'd2, v);
        check("R8 waits for bus transaction", v, 32'h20);
        done1(1, 64);
        rd(2'd2, v);
        check("R8 halted after completion", v, 32'h31);
        rd(2'd1, v);
        check("R8 completion counted", v, size_word(4, 256, 1));
        wr(2'd2, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_transfer();
        t_halt_shared();
        t_full_inflight();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule